// File: doc/BRIEF.md
# Skipped-Instruction Length Decoder

This unit works out where the next instruction begins when the current one has to be passed over because a conditional test failed. It receives the 16-bit instruction word and the program counter that points at it. It then reports how many words the instruction occupies and the address that follows it. Only the operand codes are inspected, to see whether each one pulls in an extra word. No operand is ever evaluated. Passing over an instruction therefore cannot move the stack pointer, touch a register, or read memory, even when its operands use the push or pop forms.

The length and the next address come out combinationally, in the same cycle as the instruction word. A registered copy is also captured on every clock edge where `valid_i` is high. This copy lets a fetch stage that is one cycle later pick up the skip target without a timing path back through the decoder.

Top module: `skip_len_dec`

## Requirements
- R1: The instruction word always counts as one word. A non-zero opcode (bits 3:0) whose two operand fields both need no extra word gives `len_o` = 1, and `len_o` is never outside the range 1 to 3.
- R2: An operand code from 0x10 to 0x17 (register plus next-word offset) adds exactly one word to the length.
- R3: Operand codes 0x1E and 0x1F (next-word address, next-word literal) each add exactly one word.
- R4: Every other 6-bit operand code adds no word. This covers 0x00–0x0F, 0x18–0x1D and the short literals 0x20–0x3F.
- R5: When bits 3:0 are non-zero (basic format), the fields in bits 9:4 and bits 15:10 are both examined. If both need an extra word, the length is 3.
- R6: When bits 3:0 are zero (extended format), only the field in bits 15:10 is examined. Bits 9:4 have no effect on the length, so the length is at most 2.
- R7: `next_pc_o` equals `pc_i` plus `len_o`, taken modulo 2^16.
- R8: `len_o` and `next_pc_o` depend only on the current `instr_i` and `pc_i`. They are valid in the same cycle, with no clock edge between input and output.
- R9: On a rising edge with `valid_i` high, `r_next_pc_o` and `r_len_o` take the current combinational results and `r_valid_o` goes high. With `valid_i` low, `r_valid_o` goes low and the other two registered outputs hold their values.
- R10: While `rst_n` is low, `r_valid_o`, `r_next_pc_o` and `r_len_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction word and PC are to be captured this cycle |
| instr_i | input | 16 | Instruction word being skipped |
| pc_i | input | 16 | Address of that instruction word |
| len_o | output | 2 | Instruction length in words (1 to 3), combinational |
| next_pc_o | output | 16 | Address after the skipped instruction, combinational |
| r_valid_o | output | 1 | Registered capture flag |
| r_next_pc_o | output | 16 | Registered next address |
| r_len_o | output | 2 | Registered length |

## Verification
The two functions that can fall in the same cycle are the three-word length in basic format and the wrap of the program counter past 0xFFFF. The bench provokes this by placing an instruction with both fields in the extra-word ranges at 0xFFFE. It expects 0x0001 on the combinational output and, one edge later, on the registered output. Extended-format words that carry an extra-word code in the ignored field are swept alongside the basic format, and every code in both fields is compared against a behavioural model on each clock.

// File: rtl/skl_pkg.sv
`timescale 1ns/1ps
package skl_pkg;
    // operand codes that pull one extra word from the instruction stream
    localparam logic [5:0] IDX_NW_LO = 6'h10;
    localparam logic [5:0] IDX_NW_HI = 6'h17;
    localparam logic [5:0] NW_ADDR   = 6'h1E;
    localparam logic [5:0] NW_LIT    = 6'h1F;

    typedef enum logic {
        FMT_BASIC = 1'b0,
        FMT_EXT   = 1'b1
    } skl_fmt_e;
endpackage

// File: rtl/skl_opnd_len.sv
`timescale 1ns/1ps
module skl_opnd_len #(
    parameter int unsigned FLD_W = 6
) (
    input  logic [FLD_W-1:0] code_i,
    output logic             extra_o
);
    import skl_pkg::*;

    logic in_idx;
    logic in_nw;

    always_comb begin
        in_idx  = (code_i >= FLD_W'(IDX_NW_LO)) && (code_i <= FLD_W'(IDX_NW_HI));
        in_nw   = (code_i == FLD_W'(NW_ADDR)) || (code_i == FLD_W'(NW_LIT));
        extra_o = in_idx || in_nw;
    end

    // R4: short literals never consume a word
    always_comb begin
        if (code_i[FLD_W-1]) begin
            p_short_lit_r4: assert (!extra_o);
        end
    end
endmodule

// File: rtl/skl_len_sum.sv
`timescale 1ns/1ps
module skl_len_sum #(
    parameter int unsigned OPC_W = 4,
    parameter int unsigned LEN_W = 2
) (
    input  logic [OPC_W-1:0] opcode_i,
    input  logic             extra_a_i,
    input  logic             extra_b_i,
    output skl_pkg::skl_fmt_e fmt_o,
    output logic [LEN_W-1:0] len_o
);
    import skl_pkg::*;

    logic use_a;

    always_comb begin
        fmt_o = (opcode_i == '0) ? FMT_EXT : FMT_BASIC;
        use_a = (fmt_o == FMT_BASIC) && extra_a_i;
        len_o = LEN_W'(1) + LEN_W'(extra_b_i) + LEN_W'(use_a);
    end

    // R1: the word itself is always counted
    always_comb begin
        p_min_one_r1: assert (len_o != '0);
    end
endmodule

// File: rtl/skip_len_dec.sv
`timescale 1ns/1ps
module skip_len_dec #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned OPC_W  = 4,
    parameter int unsigned FLD_W  = 6,
    parameter int unsigned LEN_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [WORD_W-1:0] instr_i,
    input  logic [WORD_W-1:0] pc_i,
    output logic [LEN_W-1:0]  len_o,
    output logic [WORD_W-1:0] next_pc_o,
    output logic              r_valid_o,
    output logic [WORD_W-1:0] r_next_pc_o,
    output logic [LEN_W-1:0]  r_len_o
);
    import skl_pkg::*;

    localparam int unsigned N_FLD = 2;

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] npc;
        logic [LEN_W-1:0]  len;
    } cap_t;

    logic [N_FLD-1:0] extra;
    skl_fmt_e         fmt;
    cap_t             cap_d, cap_q;

    // field 0 = bits 9:4, field 1 = bits 15:10
    for (genvar gi = 0; gi < N_FLD; gi++) begin : g_fld
        skl_opnd_len #(.FLD_W(FLD_W)) u_opnd (
            .code_i  (instr_i[OPC_W + gi*FLD_W +: FLD_W]),
            .extra_o (extra[gi])
        );
    end

    skl_len_sum #(.OPC_W(OPC_W), .LEN_W(LEN_W)) u_sum (
        .opcode_i  (instr_i[OPC_W-1:0]),
        .extra_a_i (extra[0]),
        .extra_b_i (extra[1]),
        .fmt_o     (fmt),
        .len_o     (len_o)
    );

    always_comb begin
        next_pc_o = pc_i + WORD_W'(len_o);
    end

    always_comb begin
        cap_d     = cap_q;
        cap_d.vld = valid_i;
        if (valid_i) begin
            cap_d.npc = next_pc_o;
            cap_d.len = len_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign r_valid_o   = cap_q.vld;
    assign r_next_pc_o = cap_q.npc;
    assign r_len_o     = cap_q.len;

    p_len_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (len_o >= LEN_W'(1)) && (len_o <= LEN_W'(3)));

    p_ext_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt == FMT_EXT) |-> (len_o != LEN_W'(3)));

    p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((&pc_i) && len_o == LEN_W'(1)) |-> (next_pc_o == '0));

    p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> (r_valid_o && r_next_pc_o == $past(next_pc_o) && r_len_o == $past(len_o)));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!r_valid_o && $stable(r_next_pc_o) && $stable(r_len_o)));
endmodule

// File: tb/skip_len_dec_bench.sv
`timescale 1ns/1ps
module skip_len_dec_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [15:0] instr_i = '0;
    logic [15:0] pc_i = '0;
    logic [1:0]  len_o;
    logic [15:0] next_pc_o;
    logic        r_valid_o;
    logic [15:0] r_next_pc_o;
    logic [1:0]  r_len_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference state for the registered outputs
    int m_vld = 0;
    int m_npc = 0;
    int m_len = 0;

    always #10 clk = ~clk;

    skip_len_dec u_skip_len_dec (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i), .pc_i(pc_i),
        .len_o(len_o), .next_pc_o(next_pc_o),
        .r_valid_o(r_valid_o), .r_next_pc_o(r_next_pc_o), .r_len_o(r_len_o)
    );

    function automatic int needs_word(int c);
        return ((c >= 16 && c <= 23) || c == 30 || c == 31) ? 1 : 0;
    endfunction

    function automatic int ref_len(logic [15:0] w);
        int n = 1 + needs_word(int'(w[15:10]));
        if (w[3:0] != 4'd0) n += needs_word(int'(w[9:4]));
        return n;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(logic [15:0] ins, logic [15:0] pc, logic v, string tag);
        int el;
        int enp;
        @(negedge clk);
        instr_i = ins; pc_i = pc; valid_i = v;
        #2;
        el  = ref_len(ins);
        enp = (int'(pc) + el) % 65536;
        chk({tag, " R8 len"}, int'(len_o), el);
        chk({tag, " R7 npc"}, int'(next_pc_o), enp);
        @(posedge clk);
        #2;
        m_vld = v ? 1 : 0;
        if (v) begin m_npc = enp; m_len = el; end
        chk("R9 r_valid", int'(r_valid_o), m_vld);
        chk("R9 r_npc", int'(r_next_pc_o), m_npc);
        chk("R9 r_len", int'(r_len_o), m_len);
    endtask

    function automatic logic [15:0] mk(int b, int a, int op);
        return {6'(b), 6'(a), 4'(op)};
    endfunction

    initial begin
        #(20 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 r_valid", int'(r_valid_o), 0);
        chk("R10 r_npc", int'(r_next_pc_o), 0);
        chk("R10 r_len", int'(r_len_o), 0);
        @(negedge clk);
        rst_n = 1'b1;

        step(mk(0, 0, 1), 16'h0100, 1, "R1");
        chk("R1 len one", int'(r_len_o), 1);
        for (int c = 16; c <= 23; c++) begin
            step(mk(c, 0, 2), 16'h0200, 1, "R2 b");
            step(mk(0, c, 3), 16'h0200, 1, "R2 a");
        end
        step(mk(30, 1, 4), 16'h0300, 1, "R3 b1E");
        step(mk(2, 31, 5), 16'h0300, 1, "R3 a1F");
        step(mk(24, 25, 6), 16'h0400, 1, "R4 18/19");
        step(mk(27, 28, 7), 16'h0400, 1, "R4 1B/1C");
        step(mk(32, 63, 8), 16'h0400, 1, "R4 lit");
        step(mk(15, 29, 9), 16'h0400, 1, "R4 0F/1D");
        step(mk(16, 30, 1), 16'h0500, 1, "R5 both");
        chk("R5 three", int'(r_len_o), 3);
        step(mk(0, 1, 0), 16'h0600, 1, "R6 ext none");
        step(mk(31, 1, 0), 16'h0600, 1, "R6 ext b");
        step(mk(0, 16, 0), 16'h0600, 1, "R6 ignore a");
        chk("R6 ignore a len", int'(r_len_o), 1);
        step(mk(23, 30, 1), 16'hFFFE, 1, "R7 wrap3");
        chk("R7 wrap value", int'(r_next_pc_o), 16'h0001);
        step(mk(0, 0, 1), 16'hFFFF, 1, "R7 wrap1");
        step(mk(17, 17, 2), 16'h1234, 0, "R9 hold");
        step(mk(20, 5, 0), 16'h2000, 0, "R9 hold2");

        for (int b = 0; b < 64; b++) begin
            for (int a = 0; a < 64; a++) begin
                step(mk(b, a, 1 + int'($urandom_range(14))), 16'($urandom), 1'($urandom), "R5 sweep");
            end
            step(mk(b, int'($urandom_range(63)), 0), 16'($urandom), 1, "R6 sweep");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule